// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write single bytes in an external asynchronous static RAM of 128K locations. A request arrives on a valid/ready port carrying a direction flag, an address and write data. The controller turns it into a timed sequence on the memory pins: two select lines of opposite polarity, an output-enable strobe, a write strobe, the address, and the write data with its own tri-state enable. Read data is sampled at the end of the access window and handed back as a one-cycle response.

Every analog timing figure of the memory is given as a parameter in picoseconds, together with the system clock period. At elaboration each figure becomes a whole number of clock cycles, rounded up, with a floor of one cycle. Writes always end on the rising edge of the write strobe. The select lines and the address stay put for one more clock after that edge, so the data-setup window is measured against the write strobe alone.

After every read there is a bus-turnaround interval at least as long as the memory's output-float time, and only then can the controller drive its own data pins. Between accesses both select lines are released, so the memory falls back to its low-power standby state.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory is deselected and idle: `sram_sel_n`=1, `sram_sel`=0, `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0. `req_ready` is high only in this idle condition.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next cycle. `req_write`=0 selects a read and `req_write`=1 selects a write. On a read the next cycle shows `sram_sel_n`=0, `sram_sel`=1, `sram_oe_n`=0, `sram_we_n`=1 and `sram_addr` equal to the request address.
- R3: A read samples `sram_dq_in` after the select lines and output enable have been active, with a steady address, for N_RD cycles. N_RD is the rounded-up maximum of read cycle time, address-to-data time and output-enable-to-data time. `rsp_valid` rises N_RD cycles after the accepting edge, stays high for exactly one cycle, and carries the sampled byte on `rsp_rdata`.
- R4: `sram_we_n` is low only while both select lines are active and `sram_oe_n` is high. Select and address are steady for at least the address-to-write-end time before `sram_we_n` rises.
- R5: The write strobe stays low for at least the write pulse width.
- R6: During a write, `sram_dq_oe` is high and `sram_dq_out` holds the request data for at least the data-setup time before `sram_we_n` rises.
- R7: A write is always ended by `sram_we_n` rising. In the cycle after that edge the select lines are still active, the address is unchanged and the data is still driven.
- R8: Select is held for each write for at least the write cycle time.
- R9: `sram_dq_oe` is never high while `sram_oe_n` is low. `sram_dq_oe` rises only after `sram_oe_n` has been high for at least the output-float time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte returned by a read |
| sram_addr | output | 17 | Memory address pins |
| sram_sel_n | output | 1 | Active-low select |
| sram_sel | output | 1 | Active-high select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable for the controller's data drivers |
| sram_dq_in | input | 8 | Data received from the memory |

## Verification
The bench builds the controller with its default figures and an 8 ns clock. This gives a six-cycle read window, a single setup cycle, a five-cycle write strobe, a recovery held at its one-cycle floor and a three-cycle turnaround. Because the recovery sits at the floor, the write cycle time is met only through the setup and strobe cycles, and the bench measures that. A memory model in the bench returns a wrong byte whenever the read window is shorter than the access time. It also measures pulse width, setup, hold, select span and float gap against the nanosecond figures, so shortening any interval shows up at the ports.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

    // Round a time in picoseconds up to whole clock cycles, never below one.
    function automatic int ps_to_cycles(int t_ps, int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wdata = req_wdata;
        end
        if (capture) begin
            dp_d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign addr  = dp_q.addr;
    assign wdata = dp_q.wdata;
    assign rdata = dp_q.rdata;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = 8000,
    parameter int T_RC_PS   = 45000,
    parameter int T_AA_PS   = 45000,
    parameter int T_DOE_PS  = 22000,
    parameter int T_HZOE_PS = 18000,
    parameter int T_WC_PS   = 45000,
    parameter int T_AS_PS   = 0,
    parameter int T_AW_PS   = 35000,
    parameter int T_PWE_PS  = 35000,
    parameter int T_SD_PS   = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_sel_n,
    output logic              sram_sel,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // Interval lengths in clock cycles
    localparam int N_RD  = imax(imax(ps_to_cycles(T_RC_PS, CLK_PS), ps_to_cycles(T_AA_PS, CLK_PS)),
                                ps_to_cycles(T_DOE_PS, CLK_PS));
    localparam int N_WS  = ps_to_cycles(T_AS_PS, CLK_PS);
    localparam int N_PWE = imax(imax(ps_to_cycles(T_PWE_PS, CLK_PS), ps_to_cycles(T_SD_PS, CLK_PS)),
                                ps_to_cycles(T_AW_PS, CLK_PS));
    localparam int N_REC_RAW = ps_to_cycles(T_WC_PS, CLK_PS) - N_WS - N_PWE;
    localparam int N_REC = (N_REC_RAW < 1) ? 1 : N_REC_RAW;
    localparam int N_TA  = ps_to_cycles(T_HZOE_PS, CLK_PS);
    localparam int N_MAX = imax(imax(N_RD, N_WS), imax(imax(N_PWE, N_REC), N_TA));
    localparam int CNT_W = $clog2(N_MAX + 1);

    typedef struct packed {
        ctrl_state_e state;
        logic        sel_n;
        logic        sel;
        logic        oe_n;
        logic        we_n;
        logic        dq_oe;
        logic        rsp_valid;
    } ctrl_regs_t;

    localparam ctrl_regs_t IDLE_REGS = '{
        state: ST_IDLE, sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1,
        we_n: 1'b1, dq_oe: 1'b0, rsp_valid: 1'b0
    };

    ctrl_regs_t       r_d, r_q;
    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    assign req_ready = (r_q.state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        capture       = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.sel_n = 1'b0;
                    r_d.sel   = 1'b1;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.state = ST_WR_SETUP;
                        r_d.dq_oe = 1'b1;
                        tmr_val   = CNT_W'(N_WS - 1);
                    end else begin
                        r_d.state = ST_RD_ACCESS;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = CNT_W'(N_RD - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    capture       = 1'b1;
                    r_d.state     = ST_RD_DONE;
                    r_d.sel_n     = 1'b1;
                    r_d.sel       = 1'b0;
                    r_d.oe_n      = 1'b1;
                    r_d.rsp_valid = 1'b1;
                end
            end
            ST_RD_DONE: begin
                r_d.state = ST_TURNAROUND;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(N_TA - 1);
            end
            ST_TURNAROUND: begin
                if (tmr_done) r_d.state = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    r_d.state = ST_WR_PULSE;
                    r_d.we_n  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(N_PWE - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    r_d.state = ST_WR_RECOVER;
                    r_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(N_REC - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.sel_n = 1'b1;
                    r_d.sel   = 1'b0;
                    r_d.dq_oe = 1'b0;
                end
            end
            default: r_d = IDLE_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= IDLE_REGS;
        else        r_q <= r_d;
    end

    sramc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (sram_dq_in),
        .addr      (sram_addr),
        .wdata     (sram_dq_out),
        .rdata     (rsp_rdata)
    );

    assign sram_sel_n = r_q.sel_n;
    assign sram_sel   = r_q.sel;
    assign sram_oe_n  = r_q.oe_n;
    assign sram_we_n  = r_q.we_n;
    assign sram_dq_oe = r_q.dq_oe;
    assign rsp_valid  = r_q.rsp_valid;

    // Window counters used only by the checks below
    logic [CNT_W:0] we_low_cnt;
    logic [CNT_W:0] oe_gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_gap_cnt <= '1;
        end else begin
            we_low_cnt <= (!r_q.we_n) ? ((we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
            oe_gap_cnt <= (r_q.oe_n) ? ((oe_gap_cnt == '1) ? oe_gap_cnt : oe_gap_cnt + 1'b1) : '0;
        end
    end

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe)); // R1
    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_sel_n && sram_sel && sram_oe_n)); // R4
    AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= (CNT_W+1)'(N_PWE))); // R5
    AST_WE_ENDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> (!sram_sel_n && sram_sel && sram_dq_oe && $stable(sram_addr))); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n)); // R9
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_gap_cnt >= (CNT_W+1)'(N_TA))); // R9
endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int CLK_PS    = 8000;
    localparam int T_RC_PS   = 45000;
    localparam int T_AA_PS   = 45000;
    localparam int T_DOE_PS  = 22000;
    localparam int T_HZOE_PS = 18000;
    localparam int T_WC_PS   = 45000;
    localparam int T_AW_PS   = 35000;
    localparam int T_PWE_PS  = 35000;
    localparam int T_SD_PS   = 25000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] sram_addr;
    logic        sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    function automatic int cyc(int t_ps);
        int c;
        c = (t_ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [7:0] init_pat(logic [16:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h3C;
    endfunction

    // Memory model contents and independent reference contents
    logic [7:0] smem [int];
    logic [7:0] rmem [int];

    function automatic logic [7:0] model_rd(logic [16:0] a);
        return smem.exists(int'(a)) ? smem[int'(a)] : init_pat(a);
    endfunction

    function automatic logic [7:0] ref_rd(logic [16:0] a);
        return rmem.exists(int'(a)) ? rmem[int'(a)] : init_pat(a);
    endfunction

    task automatic chk(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Memory model: data valid only after the access time has elapsed
    int rd_age = 0, we_age = 0, data_age = 0, sel_age = 0, oe_hi_age = 1000, sel_span = 0;
    bit had_write = 1'b0;
    logic p_sel = 1'b0, p_oe_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dq = '0;

    assign sram_dq_in = (rd_age * CLK_PS >= T_AA_PS) ? model_rd(sram_addr) : 8'hEE;

    always @(negedge clk) begin
        logic sel;
        sel = !sram_sel_n && sram_sel;
        if (rst_n) begin
            if (sram_dq_oe && !sram_oe_n) chk(1'b0, "R9 contention", 1, 0);
            if (!sram_we_n && (!sel || !sram_oe_n)) chk(1'b0, "R4 strobe", {sel, sram_oe_n}, 3);
            if (!p_we_n && sram_we_n) begin
                chk(we_age * CLK_PS >= T_PWE_PS, "R5 pulse", we_age * CLK_PS, T_PWE_PS);
                chk(data_age * CLK_PS >= T_SD_PS, "R6 data setup", data_age * CLK_PS, T_SD_PS);
                chk(sel_age * CLK_PS >= T_AW_PS, "R4 addr setup", sel_age * CLK_PS, T_AW_PS);
                chk(sel && sram_addr == p_addr && sram_dq_oe, "R7 hold", {sel, sram_dq_oe}, 3);
                smem[int'(p_addr)] = p_dq;
            end
            if (sram_dq_oe && !p_dq_oe)
                chk(oe_hi_age * CLK_PS >= T_HZOE_PS, "R9 turnaround", oe_hi_age * CLK_PS, T_HZOE_PS);
            if (p_sel && !sel && had_write)
                chk(sel_span * CLK_PS >= T_WC_PS, "R8 cycle", sel_span * CLK_PS, T_WC_PS);
        end
        rd_age    = (sel && !sram_oe_n) ? ((p_sel && !p_oe_n && sram_addr == p_addr) ? rd_age + 1 : 1) : 0;
        we_age    = (!sram_we_n) ? we_age + 1 : 0;
        data_age  = sram_dq_oe ? ((p_dq_oe && sram_dq_out == p_dq) ? data_age + 1 : 1) : 0;
        sel_age   = sel ? ((p_sel && sram_addr == p_addr) ? sel_age + 1 : 1) : 0;
        sel_span  = sel ? sel_span + 1 : 0;
        oe_hi_age = sram_oe_n ? oe_hi_age + 1 : 0;
        had_write = sel ? (had_write || !sram_we_n) : 1'b0;
        p_sel = sel; p_oe_n = sram_oe_n; p_we_n = sram_we_n; p_dq_oe = sram_dq_oe;
        p_addr = sram_addr; p_dq = sram_dq_out;
    end

    task automatic check_idle(string tag);
        chk(sram_sel_n && !sram_sel && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
            tag, {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 6'b101100);
    endtask

    task automatic do_op(bit wr, logic [16:0] a, logic [7:0] d);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy", req_ready, 0);
        if (wr) begin
            chk(!sram_sel_n && sram_sel && sram_oe_n && sram_we_n && sram_dq_oe && sram_addr == a,
                "R6 write setup", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b01111);
            rmem[int'(a)] = d;
        end else begin
            chk(!sram_sel_n && sram_sel && !sram_oe_n && sram_we_n && sram_addr == a,
                "R2 read strobes", {sram_sel_n, sram_sel, sram_oe_n, sram_we_n}, 4'b0101);
            lat = 0;
            while (!rsp_valid) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == cyc(T_RC_PS) && lat >= cyc(T_AA_PS) && lat >= cyc(T_DOE_PS),
                "R3 latency", lat, cyc(T_RC_PS));
            chk(rsp_rdata == ref_rd(a), "R3 data", rsp_rdata, ref_rd(a));
            @(negedge clk);
            chk(!rsp_valid, "R3 pulse", rsp_valid, 0);
        end
        while (!req_ready) @(negedge clk);
        check_idle("R1 idle");
    endtask

    initial begin
        int cnt = 0;
        while (!finished && cnt < 150000) begin
            @(posedge clk);
            cnt++;
        end
        if (!finished) begin
            chk(1'b0, "watchdog", cnt, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk(req_ready, "R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        // Directed corners
        do_op(1'b1, 17'h00000, 8'hA5);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b1, 17'h1FFFF, 8'h5A);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h00123, 8'h00);
        do_op(1'b1, 17'h00123, 8'hFF);
        do_op(1'b1, 17'h00123, 8'h00);
        do_op(1'b0, 17'h00123, 8'h00);
        // Random mix over a small window and the full range
        for (int i = 0; i < 250; i++) begin
            logic [16:0] a;
            a = ($urandom % 2 == 0) ? 17'($urandom % 32) : 17'($urandom);
            do_op(1'($urandom % 2), a, 8'($urandom));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule